// File: doc/BRIEF.md
# Programmable-ratio word demultiplexer

The block takes a fast stream of data words and spreads it across up to eight parallel output ports, A through H, so that downstream logic can work at a fraction of the word rate. Words are assigned to ports in arrival order, starting at port A. Once a whole group of four or eight words has arrived, all active ports are loaded together, and a one-clock data-ready pulse marks the new group. Two input clocking modes are supported. In full-rate mode one word enters per clock on the even input. In half-rate mode an even and an odd word enter together on every clock.

The configuration inputs are the ratio (1:4 or 1:8), the word width (8 or 10 bits) and the clocking mode. These inputs are sampled only at a resynchronisation point. Such a point is either the first clock after the asynchronous reset is released, or a clock on which the synchronous reset is high. A synchronous reset also throws away any half-collected group, so that the next word lands on port A again. A self-test input replaces the data inputs with an internal incrementing pattern.

The controller has two states. ST_ALIGN is entered on asynchronous reset. On its single clock it latches the configuration and captures nothing; the transition T_ALIGN_DONE then moves to ST_RUN. ST_RUN captures words on every clock. It has one self-loop, T_RESYNC, taken when the synchronous reset is high: that clock relatches the configuration, clears the port pointer and the pattern counter, and captures nothing. Asynchronous reset returns to ST_ALIGN from any state.

Top module: `word_spreader`

## Requirements
- R1: In 1:4 mode each group fills ports A–D and ports E–H read zero. In 1:8 mode each group fills ports A–H. Port A occupies dout bits [9:0] and port k occupies bits [10k+9:10k].
- R2: In 8-bit mode bits [9:8] of every port read zero. In 10-bit mode all ten bits of each port pass through.
- R3: Within a group, the k-th captured word (k from 0) appears on port k. The next word after a completed group goes to port A.
- R4: In full-rate mode (half_rate=0) one word is captured from din_even on every running clock, and din_odd is ignored.
- R5: In half-rate mode (half_rate=1) two words are captured per clock. din_even goes to the lower-numbered port and din_odd to the next port.
- R6: The ports change only on the cycle that a group completes or that a resynchronisation changes the masking. On all other cycles they hold their value.
- R7: dready is high for exactly one cycle. That cycle is the first one on which the ports show the new group, one clock edge after the last word of the group is sampled.
- R8: While arst_n is low, dout and dready are zero, without waiting for a clock.
- R9: A clock with srst high captures no word and discards any partial group. The next word goes to port A, the ports keep their value, and dready is low on the following cycle.
- R10: With self_test high the captured words come from a counter instead of the data inputs. The counter starts at 0 at each resynchronisation and advances once per captured word. In half-rate mode the even word is n and the odd word is n+1. The value is taken modulo 2^width.
- R11: ratio8, wide and half_rate are sampled only at a resynchronisation. Changing them at any other time has no effect on grouping or masking.
- R12: The first clock after arst_n rises captures no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous realignment reset, active high |
| ratio8 | input | 1 | 1 selects 1:8, 0 selects 1:4 |
| wide | input | 1 | 1 selects 10-bit words, 0 selects 8-bit words |
| half_rate | input | 1 | 1 selects even/odd pair capture, 0 selects one word per clock |
| self_test | input | 1 | Replaces the input words with the internal pattern |
| din_even | input | 10 | Even (or only) input word |
| din_odd | input | 10 | Odd input word, used in half-rate mode |
| dout | output | 80 | Ports A..H, 10 bits each, port A in the low bits |
| dready | output | 1 | One-cycle pulse marking a new group on dout |

## Verification
The bench builds the block with its default parameters: 10-bit maximum width, 8-bit narrow width and eight ports. These defaults make both group sizes, both capture step sizes and both width masks reachable. The bench sweeps all sixteen combinations of ratio, width, clocking mode and self-test, and computes each expected group arithmetically from a running word index. Separate sequences cover realignment in the middle of a group, configuration changes made without a reset, and an asynchronous reset in the middle of a run followed by the capture-free align clock.

// File: rtl/wsp_pkg.sv
`timescale 1ns/1ps
package wsp_pkg;

    typedef enum logic {
        ST_ALIGN = 1'b0,
        ST_RUN   = 1'b1
    } wsp_state_t;

    typedef struct packed {
        logic ratio8;
        logic wide;
        logic half;
    } wsp_cfg_t;

    localparam wsp_cfg_t CFG_DEFAULT = '{ratio8: 1'b1, wide: 1'b1, half: 1'b0};

endpackage

// File: rtl/wsp_ctrl.sv
`timescale 1ns/1ps
module wsp_ctrl
    import wsp_pkg::*;
#(
    parameter int NP = 8,
    localparam int PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          srst,
    input  wsp_cfg_t      cfg_in,
    output wsp_cfg_t      cfg_q,
    output logic          cap,
    output logic          restart,
    output logic          last,
    output logic [PW-1:0] ptr
);

    localparam logic [PW:0] GRP_FULL = (PW+1)'(NP);
    localparam logic [PW:0] GRP_HALF = (PW+1)'(NP/2);

    wsp_state_t  state_q;
    wsp_state_t  state_nx;
    logic [PW:0] ptr_sum;
    logic [PW:0] grp_size;
    logic [PW:0] step;

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_ALIGN;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: T_ALIGN_DONE leaves ST_ALIGN, T_RESYNC loops in ST_RUN
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_ALIGN: state_nx = ST_RUN;
            ST_RUN:   state_nx = ST_RUN;
            default:  state_nx = ST_ALIGN;
        endcase
    end

    // state outputs
    always_comb begin
        cap     = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            ST_ALIGN: begin
                restart = 1'b1;
            end
            ST_RUN: begin
                restart = srst;
                cap     = !srst;
            end
            default: begin
                restart = 1'b1;
            end
        endcase
    end

    assign step     = cfg_q.half   ? (PW+1)'(2) : (PW+1)'(1);
    assign grp_size = cfg_q.ratio8 ? GRP_FULL   : GRP_HALF;
    assign ptr_sum  = {1'b0, ptr} + step;
    assign last     = cap && (ptr_sum == grp_size);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cfg_q <= CFG_DEFAULT;
            ptr   <= '0;
        end else if (restart) begin
            cfg_q <= cfg_in;
            ptr   <= '0;
        end else if (cap) begin
            ptr   <= last ? '0 : ptr_sum[PW-1:0];
        end
    end

endmodule

// File: rtl/wsp_pattern.sv
`timescale 1ns/1ps
module wsp_pattern #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         restart,
    input  logic         cap,
    input  logic         half,
    output logic [W-1:0] pat_even,
    output logic [W-1:0] pat_odd
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cap) begin
            cnt_q <= cnt_q + (half ? W'(2) : W'(1));
        end
    end

    assign pat_even = cnt_q;
    assign pat_odd  = cnt_q + W'(1);

endmodule

// File: rtl/wsp_collect.sv
`timescale 1ns/1ps
module wsp_collect #(
    parameter int NP = 8,
    parameter int W  = 10,
    localparam int PW = $clog2(NP)
) (
    input  logic                  clk,
    input  logic                  arst_n,
    input  logic                  cap,
    input  logic                  last,
    input  logic                  half,
    input  logic                  ratio8,
    input  logic [PW-1:0]         ptr,
    input  logic [W-1:0]          w_even,
    input  logic [W-1:0]          w_odd,
    output logic [NP-1:0][W-1:0]  port_q,
    output logic                  ready_q
);

    logic [PW-1:0]         ptr_nx;
    logic [NP-1:0][W-1:0]  buf_q;

    assign ptr_nx = ptr + PW'(1);

    for (genvar i = 0; i < NP; i++) begin : g_port
        localparam bit LOWER = (i < NP/2);
        logic hit_even;
        logic hit_odd;
        logic load;

        assign hit_even = cap && (ptr == PW'(i));
        assign hit_odd  = cap && half && (ptr_nx == PW'(i));
        assign load     = last && (ratio8 || LOWER);

        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                buf_q[i] <= '0;
            end else if (hit_even) begin
                buf_q[i] <= w_even;
            end else if (hit_odd) begin
                buf_q[i] <= w_odd;
            end
        end

        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                port_q[i] <= '0;
            end else if (load) begin
                if (hit_even) begin
                    port_q[i] <= w_even;
                end else if (hit_odd) begin
                    port_q[i] <= w_odd;
                end else begin
                    port_q[i] <= buf_q[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= last;
        end
    end

endmodule

// File: rtl/word_spreader.sv
`timescale 1ns/1ps
module word_spreader
    import wsp_pkg::*;
#(
    parameter int W  = 10,
    parameter int WN = 8,
    parameter int NP = 8
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic            srst,
    input  logic            ratio8,
    input  logic            wide,
    input  logic            half_rate,
    input  logic            self_test,
    input  logic [W-1:0]    din_even,
    input  logic [W-1:0]    din_odd,
    output logic [NP*W-1:0] dout,
    output logic            dready
);

    localparam int PW = $clog2(NP);
    localparam logic [W-1:0] NARROW_MASK = {{(W-WN){1'b0}}, {WN{1'b1}}};

    wsp_cfg_t              cfg_in;
    wsp_cfg_t              cfg_q;
    logic                  cap;
    logic                  restart;
    logic                  last;
    logic [PW-1:0]         ptr;
    logic [W-1:0]          pat_even;
    logic [W-1:0]          pat_odd;
    logic [W-1:0]          w_even;
    logic [W-1:0]          w_odd;
    logic [NP-1:0][W-1:0]  port_q;
    logic [W-1:0]          wmask;
    logic                  cfg_ratio8;
    logic                  cfg_wide;

    assign cfg_in = '{ratio8: ratio8, wide: wide, half: half_rate};

    wsp_ctrl #(.NP(NP)) u_ctrl (
        .clk     (clk),
        .arst_n  (arst_n),
        .srst    (srst),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .cap     (cap),
        .restart (restart),
        .last    (last),
        .ptr     (ptr)
    );

    wsp_pattern #(.W(W)) u_pat (
        .clk      (clk),
        .arst_n   (arst_n),
        .restart  (restart),
        .cap      (cap),
        .half     (cfg_q.half),
        .pat_even (pat_even),
        .pat_odd  (pat_odd)
    );

    assign w_even = self_test ? pat_even : din_even;
    assign w_odd  = self_test ? pat_odd  : din_odd;

    wsp_collect #(.NP(NP), .W(W)) u_col (
        .clk     (clk),
        .arst_n  (arst_n),
        .cap     (cap),
        .last    (last),
        .half    (cfg_q.half),
        .ratio8  (cfg_q.ratio8),
        .ptr     (ptr),
        .w_even  (w_even),
        .w_odd   (w_odd),
        .port_q  (port_q),
        .ready_q (dready)
    );

    assign cfg_ratio8 = cfg_q.ratio8;
    assign cfg_wide   = cfg_q.wide;
    assign wmask      = cfg_wide ? {W{1'b1}} : NARROW_MASK;

    for (genvar i = 0; i < NP; i++) begin : g_out
        localparam bit LOWER = (i < NP/2);
        assign dout[i*W +: W] = (cfg_ratio8 || LOWER) ? (port_q[i] & wmask) : '0;
    end

endmodule

// File: rtl/wsp_chk.sv
`timescale 1ns/1ps
module wsp_chk #(
    parameter int W  = 10,
    parameter int WN = 8,
    parameter int NP = 8
) (
    input logic            clk,
    input logic            arst_n,
    input logic            srst,
    input logic            dready,
    input logic [NP*W-1:0] dout,
    input logic            cfg_ratio8,
    input logic            cfg_wide
);

    logic hi_any;

    always_comb begin
        hi_any = 1'b0;
        for (int i = 0; i < NP; i++) begin
            hi_any = hi_any | (|dout[i*W+WN +: W-WN]);
        end
    end

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
        dready |=> !dready); // R7

    AST_PORTS_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        (!dready && !$past(srst)) |-> $stable(dout)); // R6

    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
        !cfg_wide |-> !hi_any); // R2

    AST_UPPER_PORTS_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
        !cfg_ratio8 |-> (dout[NP*W-1:(NP/2)*W] == '0)); // R1

    AST_RESYNC_NO_READY: assert property (@(posedge clk) disable iff (!arst_n)
        srst |=> !dready); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !arst_n |-> (dout == '0 && !dready)); // R8

endmodule

bind word_spreader wsp_chk #(.W(W), .WN(WN), .NP(NP)) u_chk (
    .clk        (clk),
    .arst_n     (arst_n),
    .srst       (srst),
    .dready     (dready),
    .dout       (dout),
    .cfg_ratio8 (cfg_ratio8),
    .cfg_wide   (cfg_wide)
);

// File: tb/word_spreader_tb.sv
`timescale 1ns/1ps
module word_spreader_tb;

    logic        clk = 1'b0;
    logic        arst_n = 1'b1;
    logic        srst = 1'b0;
    logic        ratio8 = 1'b1;
    logic        wide = 1'b1;
    logic        half_rate = 1'b0;
    logic        self_test = 1'b0;
    logic [9:0]  din_even = '0;
    logic [9:0]  din_odd = '0;
    logic [79:0] dout;
    logic        dready;

    int checks = 0;
    int fails  = 0;
    int gidx   = 0;
    bit done   = 1'b0;

    // bench model
    logic [9:0] m_raw [8];
    logic [9:0] m_buf [8];
    logic       m_r8 = 1'b1, m_wd = 1'b1, m_hf = 1'b0;
    logic       m_align = 1'b1;
    logic       m_rdy = 1'b0;
    int         m_ptr = 0;
    logic [9:0] m_k = '0;

    always #2 clk = ~clk;

    word_spreader u_dut (
        .clk       (clk),
        .arst_n    (arst_n),
        .srst      (srst),
        .ratio8    (ratio8),
        .wide      (wide),
        .half_rate (half_rate),
        .self_test (self_test),
        .din_even  (din_even),
        .din_odd   (din_odd),
        .dout      (dout),
        .dready    (dready)
    );

    function automatic logic [79:0] exp_flat();
        logic [79:0] f;
        for (int i = 0; i < 8; i++) begin
            logic [9:0] v;
            v = m_raw[i];
            if (!m_wd) v = v & 10'h0FF;
            if (!m_r8 && i >= 4) v = '0;
            f[i*10 +: 10] = v;
        end
        return f;
    endfunction

    function automatic logic [9:0] dat(input int n);
        return 10'((n * 157 + 5) & 10'h3FF);
    endfunction

    task automatic model_arst();
        for (int i = 0; i < 8; i++) begin
            m_raw[i] = '0;
            m_buf[i] = '0;
        end
        m_r8 = 1'b1; m_wd = 1'b1; m_hf = 1'b0;
        m_align = 1'b1; m_rdy = 1'b0; m_ptr = 0; m_k = '0;
    endtask

    task automatic check_out(input string tag);
        logic [79:0] e;
        e = exp_flat();
        checks++;
        if (dready !== m_rdy) begin
            fails++;
            $display("FAIL %s: dready=%0b expected %0b", tag, dready, m_rdy);
        end
        checks++;
        if (dout !== e) begin
            fails++;
            $display("FAIL %s: dout=%h expected %h", tag, dout, e);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic tick(input logic [9:0] we, input logic [9:0] wo,
                        input logic sr, input string tag);
        int g;
        int s;
        logic [9:0] e;
        logic [9:0] o;
        din_even = we;
        din_odd  = wo;
        srst     = sr;
        @(posedge clk);
        if (m_align || sr) begin
            m_r8 = ratio8; m_wd = wide; m_hf = half_rate;
            m_ptr = 0; m_k = '0; m_rdy = 1'b0; m_align = 1'b0;
        end else begin
            g = m_r8 ? 8 : 4;
            s = m_hf ? 2 : 1;
            e = self_test ? m_k : we;
            o = self_test ? (m_k + 10'd1) : wo;
            m_buf[m_ptr] = e;
            if (m_hf) m_buf[m_ptr+1] = o;
            m_k   = m_k + 10'(s);
            m_ptr = m_ptr + s;
            m_rdy = 1'b0;
            if (m_ptr == g) begin
                for (int i = 0; i < g; i++) m_raw[i] = m_buf[i];
                m_ptr = 0;
                m_rdy = 1'b1;
            end
        end
        #1;
        check_out(tag);
        @(negedge clk);
    endtask

    task automatic data_tick(input string tag);
        tick(dat(gidx), dat(gidx) ^ 10'h2A5, 1'b0, tag);
        gidx++;
    endtask

    task automatic run_cfg(input logic r8, input logic wd, input logic hf,
                           input logic bi, input int ng);
        int n;
        ratio8 = r8; wide = wd; half_rate = hf; self_test = bi;
        tick(10'h3FF, 10'h3FF, 1'b1, "R9 R11 resync latch");
        n = ng * (r8 ? 8 : 4) / (hf ? 2 : 1);
        for (int j = 0; j < n; j++) begin
            data_tick("R1 R2 R3 R4 R5 R6 R7 R10 sweep");
        end
    endtask

    initial begin
        #1;
        arst_n = 1'b0;
        model_arst();
        #2;
        // R8: reset state
        checks++;
        if (dout !== '0 || dready !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset: dout=%h dready=%0b expected 0 0", dout, dready);
        end
        @(negedge clk);
        arst_n = 1'b1;
        // R12: first clock after release captures nothing
        tick(10'h155, 10'h0AA, 1'b0, "R12 align clock");
        for (int j = 0; j < 8; j++) data_tick("R12 R3 first group");

        // sweep of every configuration
        for (int c = 0; c < 16; c++) begin
            run_cfg(c[0], c[1], c[2], c[3], 3);
        end

        // R9: realignment in the middle of a group
        run_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1);
        for (int j = 0; j < 3; j++) data_tick("R9 partial");
        tick(10'h111, 10'h222, 1'b1, "R9 srst mid group");
        for (int j = 0; j < 8; j++) data_tick("R9 realigned group");

        // R9 in half-rate 1:4
        run_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1);
        data_tick("R9 half partial");
        tick(10'h0F0, 10'h00F, 1'b1, "R9 half srst");
        for (int j = 0; j < 4; j++) data_tick("R9 R5 half realigned");

        // R11: configuration change without resynchronisation is ignored
        run_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1);
        for (int j = 0; j < 4; j++) data_tick("R11 before change");
        ratio8 = 1'b0; wide = 1'b0; half_rate = 1'b1;
        for (int j = 0; j < 12; j++) data_tick("R11 change ignored");
        tick(10'h0, 10'h0, 1'b1, "R11 latch on srst");
        for (int j = 0; j < 4; j++) data_tick("R11 new config");

        // R8 and R12: asynchronous reset mid-run
        run_cfg(1'b1, 1'b1, 1'b0, 1'b1, 0);
        for (int j = 0; j < 5; j++) data_tick("R10 pre-reset");
        arst_n = 1'b0;
        model_arst();
        #1;
        checks++;
        if (dout !== '0 || dready !== 1'b0) begin
            fails++;
            $display("FAIL R8 async clear: dout=%h dready=%0b expected 0 0", dout, dready);
        end
        @(negedge clk);
        arst_n = 1'b1;
        ratio8 = 1'b0; wide = 1'b1; half_rate = 1'b0; self_test = 1'b0;
        tick(10'h3C3, 10'h3C3, 1'b0, "R12 align after async");
        for (int j = 0; j < 8; j++) data_tick("R12 R1 after async");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule